// File: doc/BRIEF.md
# Register-File Data Stack Engine

This block keeps an integer data stack inside a window of a general-purpose register file and reaches every operand by index instead of by memory load. A top-of-stack index and three registered companion indices (one, two and three levels below the top) select the entries that a stack word reads and writes. After each word the companions are recomputed from the new top index, so the next word starts with all four indices ready.

The engine runs seven words: push, drop, dup, swap, over, rot and add. A word is offered on a valid/ready command port together with an optional push value. The engine takes one cycle to accept the word and a second cycle to check depth, do the indexed reads, writes and arithmetic, and move the indices. Words that would read below the bottom of the stack raise an underflow flag, and words that would grow a full stack raise an overflow flag. In both cases the register file and the indices are left as they were.

Top module: `rf_stack_engine`

## Requirements
- R1: After reset the top index is 31 (empty), the companion indices are 30, 29 and 28, both error flags are low, cmd_ready is high and top_data is 0.
- R2: After every completed word the three companion outputs equal the top index minus 1, minus 2 and minus 3.
- R3: Push (cmd_op 0) writes cmd_data to entry top+1 and raises the top index by one. A push when the top index is 127 sets err_overflow and changes nothing.
- R4: Drop (cmd_op 1) lowers the top index by one and leaves the entries below it untouched.
- R5: Dup (cmd_op 2) copies entry top to top+1, and over (cmd_op 4) copies entry top-1 to top+1. Both raise the top index by one, and both set err_overflow and change nothing when the top index is 127.
- R6: Swap (cmd_op 3) exchanges entries top and top-1 and keeps the top index.
- R7: Rot (cmd_op 5) moves entry top-2 to the top and shifts the former top and top-1 down one level each, keeping the top index.
- R8: Add (cmd_op 6) writes the sum of entries top and top-1, modulo 2^DATA_W, to entry top-1 and lowers the top index by one.
- R9: The depth (top index minus 31) must be at least 2 for add, swap and over, 3 for rot and 1 for dup and drop. A word with less depth sets err_underflow and changes neither indices nor entries.
- R10: cmd_ready drops for exactly one cycle after a word is accepted. The new indices, top_data and flags appear after the second rising edge.
- R11: cmd_op 7 is a no-operation. It completes like any word and changes neither indices nor entries.
- R12: The error flags describe the most recently completed word. A word that completes without error clears both flags, and the two flags are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A stack word is offered |
| cmd_ready | output | 1 | The engine can accept a word this cycle |
| cmd_op | input | 3 | Word code: 0 push, 1 drop, 2 dup, 3 swap, 4 over, 5 rot, 6 add, 7 no-op |
| cmd_data | input | DATA_W | Value written by push |
| top_data | output | DATA_W | Entry at the top index, 0 when the stack is empty |
| idx_top | output | IDX_W | Top-of-stack register index |
| idx_n1 | output | IDX_W | Index one level below the top |
| idx_n2 | output | IDX_W | Index two levels below the top |
| idx_n3 | output | IDX_W | Index three levels below the top |
| err_underflow | output | 1 | Last word lacked the required depth |
| err_overflow | output | 1 | Last word tried to grow a full stack |

## Verification
The assertions assume cmd_op and cmd_data are steady whenever cmd_valid is sampled with cmd_ready high. They also assume that, outside reset, the top index only moves by one per word and stays between 31 and 127. The bench drives inputs only at falling edges and holds cmd_valid for a single accepting cycle, so no word is offered while the engine is busy. It walks the stack from empty through every word to the full 96-entry limit and back, so that underflow and overflow are reached only through legal word sequences.

// File: rtl/rfs_pkg.sv
`timescale 1ns/1ps
package rfs_pkg;

   typedef enum logic [2:0] {
      W_PUSH = 3'd0,
      W_DROP = 3'd1,
      W_DUP  = 3'd2,
      W_SWAP = 3'd3,
      W_OVER = 3'd4,
      W_ROT  = 3'd5,
      W_ADD  = 3'd6,
      W_NOP  = 3'd7
   } word_e;

   typedef enum logic [1:0] {
      ST_HOLD = 2'd0,
      ST_INC  = 2'd1,
      ST_DEC  = 2'd2
   } step_e;

   // operands a word must find on the stack before it may run
   function automatic int unsigned need_depth(word_e w);
      case (w)
         W_DROP, W_DUP:         return 1;
         W_SWAP, W_OVER, W_ADD: return 2;
         W_ROT:                 return 3;
         default:               return 0;
      endcase
   endfunction

   // words that leave one more entry on the stack
   function automatic logic grows(word_e w);
      return (w == W_PUSH) || (w == W_DUP) || (w == W_OVER);
   endfunction

endpackage

// File: rtl/rfs_index_unit.sv
`timescale 1ns/1ps
module rfs_index_unit
   import rfs_pkg::*;
#(
   parameter int IDX_W = 7,
   parameter int BASE  = 32,
   parameter int TOP   = 127
) (
   input  logic             clk,
   input  logic             rst_n,
   input  step_e            step,
   output logic [IDX_W-1:0] tos,
   output logic [IDX_W-1:0] n1,
   output logic [IDX_W-1:0] n2,
   output logic [IDX_W-1:0] n3,
   output logic [IDX_W-1:0] tos_p1,
   output logic [IDX_W-1:0] depth,
   output logic             full
);
   localparam int LEVELS = 4;
   localparam logic [IDX_W-1:0] EMPTY_I = IDX_W'(BASE - 1);
   localparam logic [IDX_W-1:0] TOP_I   = IDX_W'(TOP);

   logic [IDX_W-1:0] nxt;
   logic [IDX_W-1:0] lvl [LEVELS];

   always_comb begin
      case (step)
         ST_INC:  nxt = lvl[0] + 1'b1;
         ST_DEC:  nxt = lvl[0] - 1'b1;
         default: nxt = lvl[0];
      endcase
   end

   // one register per level, all reloaded from the same next top index
   for (genvar k = 0; k < LEVELS; k++) begin : g_lvl
      localparam logic [IDX_W-1:0] OFS = IDX_W'(k);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl[k] <= EMPTY_I - OFS;
         else        lvl[k] <= nxt - OFS;
      end
   end

   assign tos    = lvl[0];
   assign n1     = lvl[1];
   assign n2     = lvl[2];
   assign n3     = lvl[3];
   assign tos_p1 = lvl[0] + 1'b1;
   assign depth  = lvl[0] - EMPTY_I;
   assign full   = (lvl[0] == TOP_I);

   // R9: the top index never leaves the stack window plus its empty slot
   p_tos_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (tos >= EMPTY_I) && (tos <= TOP_I));

   // R2: the top index moves by at most one place per word
   p_tos_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(tos) |-> ((tos == IDX_W'($past(tos) + 1'b1)) ||
                         (tos == IDX_W'($past(tos) - 1'b1))));

endmodule

// File: rtl/rfs_regfile.sv
`timescale 1ns/1ps
module rfs_regfile #(
   parameter int DATA_W         = 32,
   parameter int IDX_W          = 7,
   parameter int BASE           = 32,
   parameter int TOP            = 127,
   parameter int NWR            = 3,
   parameter int NRD            = 3,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NWR-1:0]             we,
   input  logic [NWR-1:0][IDX_W-1:0]  widx,
   input  logic [NWR-1:0][DATA_W-1:0] wdata,
   input  logic [NRD-1:0][IDX_W-1:0]  ridx,
   output logic [NRD-1:0][DATA_W-1:0] rdata
);
   localparam int DEPTH = TOP - BASE + 1;
   localparam int OFF_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] BASE_I = IDX_W'(BASE);
   localparam logic [IDX_W-1:0] TOP_I  = IDX_W'(TOP);

   logic [DATA_W-1:0] ent [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(BASE + e);
      logic [DATA_W-1:0] q;
      logic              hit;
      logic [DATA_W-1:0] d;

      always_comb begin
         hit = 1'b0;
         d   = q;
         for (int p = 0; p < NWR; p++) begin
            if (we[p] && (widx[p] == MY_IDX)) begin
               hit = 1'b1;
               d   = wdata[p];
            end
         end
      end

      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)   q <= '0;
            else if (hit) q <= d;
         end
      end else begin : g_keep
         always_ff @(posedge clk) begin
            if (hit) q <= d;
         end
      end

      assign ent[e] = q;
   end

   // indices outside the window read as zero
   for (genvar r = 0; r < NRD; r++) begin : g_rd
      logic [IDX_W-1:0] off;
      logic             in_win;
      assign off      = ridx[r] - BASE_I;
      assign in_win   = (ridx[r] >= BASE_I) && (ridx[r] <= TOP_I);
      assign rdata[r] = in_win ? ent[off[OFF_W-1:0]] : '0;
   end

   // R7: a word never aims two write ports at one entry
   for (genvar a = 0; a < NWR; a++) begin : g_chk_a
      for (genvar b = a + 1; b < NWR; b++) begin : g_chk_b
         p_distinct_wr_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (we[a] && we[b]) |-> (widx[a] != widx[b]));
      end
   end

endmodule

// File: rtl/rfs_word_ctrl.sv
`timescale 1ns/1ps
module rfs_word_ctrl
   import rfs_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int IDX_W  = 7,
   parameter int NWR    = 3
) (
   input  word_e                      op,
   input  logic [DATA_W-1:0]          push_val,
   input  logic [IDX_W-1:0]           tos,
   input  logic [IDX_W-1:0]           n1,
   input  logic [IDX_W-1:0]           n2,
   input  logic [IDX_W-1:0]           tos_p1,
   input  logic [IDX_W-1:0]           depth,
   input  logic                       full,
   input  logic [DATA_W-1:0]          rd_t,
   input  logic [DATA_W-1:0]          rd_1,
   input  logic [DATA_W-1:0]          rd_2,
   output logic [NWR-1:0]             we,
   output logic [NWR-1:0][IDX_W-1:0]  widx,
   output logic [NWR-1:0][DATA_W-1:0] wdata,
   output step_e                      step,
   output logic                       udf,
   output logic                       ovf
);
   logic fault;

   always_comb begin
      udf   = (32'(depth) < need_depth(op));
      ovf   = !udf && grows(op) && full;
      fault = udf || ovf;
      we    = '0;
      widx  = '0;
      wdata = '0;
      step  = ST_HOLD;
      if (!fault) begin
         case (op)
            W_PUSH: begin
               we[0] = 1'b1; widx[0] = tos_p1; wdata[0] = push_val;
               step  = ST_INC;
            end
            W_DROP: step = ST_DEC;
            W_DUP: begin
               we[0] = 1'b1; widx[0] = tos_p1; wdata[0] = rd_t;
               step  = ST_INC;
            end
            W_OVER: begin
               we[0] = 1'b1; widx[0] = tos_p1; wdata[0] = rd_1;
               step  = ST_INC;
            end
            W_SWAP: begin
               we[0] = 1'b1; widx[0] = tos; wdata[0] = rd_1;
               we[1] = 1'b1; widx[1] = n1;  wdata[1] = rd_t;
            end
            W_ROT: begin
               we[0] = 1'b1; widx[0] = n2;  wdata[0] = rd_1;
               we[1] = 1'b1; widx[1] = n1;  wdata[1] = rd_t;
               we[2] = 1'b1; widx[2] = tos; wdata[2] = rd_2;
            end
            W_ADD: begin
               we[0] = 1'b1; widx[0] = n1; wdata[0] = rd_t + rd_1;
               step  = ST_DEC;
            end
            default: step = ST_HOLD;
         endcase
      end
   end

endmodule

// File: rtl/rf_stack_engine.sv
`timescale 1ns/1ps
module rf_stack_engine
   import rfs_pkg::*;
#(
   parameter int DATA_W         = 32,
   parameter int IDX_W          = 7,
   parameter int BASE           = 32,
   parameter int TOP            = 127,
   parameter bit CLEAR_ON_RESET = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   output logic              cmd_ready,
   input  logic [2:0]        cmd_op,
   input  logic [DATA_W-1:0] cmd_data,
   output logic [DATA_W-1:0] top_data,
   output logic [IDX_W-1:0]  idx_top,
   output logic [IDX_W-1:0]  idx_n1,
   output logic [IDX_W-1:0]  idx_n2,
   output logic [IDX_W-1:0]  idx_n3,
   output logic              err_underflow,
   output logic              err_overflow
);
   localparam int NWR = 3;
   localparam int NRD = 3;

   if (BASE < 4) begin : g_bad_base
      $error("BASE must leave room for three derived indices below it");
   end
   if (TOP <= BASE) begin : g_bad_top
      $error("TOP must lie above BASE");
   end
   if (TOP >= (1 << IDX_W)) begin : g_bad_idx
      $error("IDX_W too narrow for TOP");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic              busy;
   word_e             op_q;
   logic [DATA_W-1:0] data_q;
   logic              accept;

   logic [IDX_W-1:0]  tos, n1, n2, n3, tos_p1, depth;
   logic              full;
   step_e             step_c, step_g;

   logic [NWR-1:0]             we_c, we_g;
   logic [NWR-1:0][IDX_W-1:0]  widx_c;
   logic [NWR-1:0][DATA_W-1:0] wdata_c;
   logic [NRD-1:0][IDX_W-1:0]  ridx;
   logic [NRD-1:0][DATA_W-1:0] rdata;
   logic                       udf_c, ovf_c;

   assign cmd_ready = !busy;
   assign accept    = cmd_valid && cmd_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy          <= 1'b0;
         op_q          <= W_NOP;
         data_q        <= '0;
         err_underflow <= 1'b0;
         err_overflow  <= 1'b0;
      end else begin
         if (accept) begin
            busy   <= 1'b1;
            op_q   <= word_e'(cmd_op);
            data_q <= cmd_data;
         end else if (busy) begin
            busy <= 1'b0;
         end
         if (busy) begin
            err_underflow <= udf_c;
            err_overflow  <= ovf_c;
         end
      end
   end

   assign step_g = busy ? step_c : ST_HOLD;
   assign we_g   = busy ? we_c : '0;
   assign ridx   = {n2, n1, tos};

   rfs_index_unit #(.IDX_W(IDX_W), .BASE(BASE), .TOP(TOP)) u_idx (
      .clk    (clk),
      .rst_n  (rst_n),
      .step   (step_g),
      .tos    (tos),
      .n1     (n1),
      .n2     (n2),
      .n3     (n3),
      .tos_p1 (tos_p1),
      .depth  (depth),
      .full   (full)
   );

   rfs_regfile #(
      .DATA_W(DATA_W), .IDX_W(IDX_W), .BASE(BASE), .TOP(TOP),
      .NWR(NWR), .NRD(NRD), .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_rf (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (we_g),
      .widx  (widx_c),
      .wdata (wdata_c),
      .ridx  (ridx),
      .rdata (rdata)
   );

   rfs_word_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W), .NWR(NWR)) u_ctrl (
      .op       (op_q),
      .push_val (data_q),
      .tos      (tos),
      .n1       (n1),
      .n2       (n2),
      .tos_p1   (tos_p1),
      .depth    (depth),
      .full     (full),
      .rd_t     (rdata[0]),
      .rd_1     (rdata[1]),
      .rd_2     (rdata[2]),
      .we       (we_c),
      .widx     (widx_c),
      .wdata    (wdata_c),
      .step     (step_c),
      .udf      (udf_c),
      .ovf      (ovf_c)
   );

   assign top_data = rdata[0];
   assign idx_top  = tos;
   assign idx_n1   = n1;
   assign idx_n2   = n2;
   assign idx_n3   = n3;

   // R10: after an accept the engine is busy for the following cycle
   p_ready_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !cmd_ready);

   // R10: indices move only on the execute edge
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_ready |=> $stable(idx_top));

   // R3: a word reporting overflow leaves the top index unchanged
   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_overflow) |-> $stable(idx_top));

   // R9: a word reporting underflow leaves the top index unchanged
   p_underflow_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_underflow) |-> $stable(idx_top));

   // R12: at most one error flag at a time
   p_flags_excl_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({err_underflow, err_overflow}));

endmodule

// File: tb/tb_rf_stack_engine.sv
`timescale 1ns/1ps
module tb_rf_stack_engine;
   localparam int DW = 32;
   localparam int IW = 7;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cmd_valid = 1'b0;
   logic          cmd_ready;
   logic [2:0]    cmd_op = 3'd7;
   logic [DW-1:0] cmd_data = '0;
   logic [DW-1:0] top_data;
   logic [IW-1:0] idx_top, idx_n1, idx_n2, idx_n3;
   logic          err_underflow, err_overflow;

   always #2 clk = ~clk;

   rf_stack_engine dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
      .cmd_op(cmd_op), .cmd_data(cmd_data), .top_data(top_data),
      .idx_top(idx_top), .idx_n1(idx_n1), .idx_n2(idx_n2), .idx_n3(idx_n3),
      .err_underflow(err_underflow), .err_overflow(err_overflow)
   );

   typedef struct {
      string         tag;
      int            top;
      logic [DW-1:0] td;
      bit            udf;
      bit            ovf;
   } exp_t;

   exp_t          sb[$];
   logic [DW-1:0] m [128];
   int            mt = 31;
   int            checks = 0;
   int            fails = 0;
   bit            finished = 0;

   task automatic chk(input bit ok, input string what,
                      input logic [DW-1:0] act, input logic [DW-1:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
      end
   endtask

   function automatic int need(input logic [2:0] op);
      case (op)
         3'd1, 3'd2:       return 1;
         3'd3, 3'd4, 3'd6: return 2;
         3'd5:             return 3;
         default:          return 0;
      endcase
   endfunction

   // reference model of the requirements, then drive the word
   task automatic issue(input logic [2:0] op, input logic [DW-1:0] d, input string tag);
      exp_t e;
      logic [DW-1:0] t;
      bit u, o;
      u = (mt - 31) < need(op);
      o = !u && (op == 3'd0 || op == 3'd2 || op == 3'd4) && (mt == 127);
      if (!u && !o) begin
         case (op)
            3'd0: begin m[mt+1] = d; mt++; end
            3'd1: mt--;
            3'd2: begin m[mt+1] = m[mt]; mt++; end
            3'd3: begin t = m[mt]; m[mt] = m[mt-1]; m[mt-1] = t; end
            3'd4: begin m[mt+1] = m[mt-1]; mt++; end
            3'd5: begin t = m[mt-2]; m[mt-2] = m[mt-1]; m[mt-1] = m[mt]; m[mt] = t; end
            3'd6: begin m[mt-1] = m[mt] + m[mt-1]; mt--; end
            default: ;
         endcase
      end
      e.tag = tag; e.top = mt; e.udf = u; e.ovf = o;
      e.td  = (mt >= 32) ? m[mt] : '0;
      @(negedge clk);
      while (!cmd_ready) @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_data = d;
      sb.push_back(e);
      @(negedge clk);
      cmd_valid = 1'b0;
      chk(cmd_ready == 1'b0, {"R10 busy after accept: ", tag}, {31'b0, cmd_ready}, '0);
   endtask

   // monitor: compare when a word completes (ready returns high)
   initial begin
      bit prev = 1'b1;
      forever begin
         @(negedge clk);
         if (rst_n && !prev && cmd_ready) begin
            if (sb.size() == 0) begin
               chk(1'b0, "R10 unexpected completion", '0, '0);
            end else begin
               exp_t e;
               e = sb.pop_front();
               chk(idx_top == IW'(e.top), {e.tag, " top index"}, DW'(idx_top), DW'(e.top));
               chk(idx_n1 == IW'(e.top - 1), {"R2 n1 ", e.tag}, DW'(idx_n1), DW'(e.top - 1));
               chk(idx_n2 == IW'(e.top - 2), {"R2 n2 ", e.tag}, DW'(idx_n2), DW'(e.top - 2));
               chk(idx_n3 == IW'(e.top - 3), {"R2 n3 ", e.tag}, DW'(idx_n3), DW'(e.top - 3));
               chk(top_data == e.td, {e.tag, " top data"}, top_data, e.td);
               chk(err_underflow == e.udf, {"R9 underflow flag ", e.tag},
                   DW'(err_underflow), DW'(e.udf));
               chk(err_overflow == e.ovf, {"R12 overflow flag ", e.tag},
                   DW'(err_overflow), DW'(e.ovf));
            end
         end
         prev = cmd_ready;
      end
   end

   initial begin
      #(200000 * 4);
      if (!finished) begin
         fails++;
         $display("FAIL R10 watchdog expired actual=0 expected=1");
         $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk(idx_top == 7'd31, "R1 top index", DW'(idx_top), 31);
      chk(idx_n1 == 7'd30 && idx_n2 == 7'd29 && idx_n3 == 7'd28, "R1 derived",
          {idx_n1, idx_n2, idx_n3}, {7'd30, 7'd29, 7'd28});
      chk(!err_underflow && !err_overflow, "R1 flags", {err_underflow, err_overflow}, '0);
      chk(cmd_ready == 1'b1, "R1 ready", DW'(cmd_ready), 1);
      chk(top_data == '0, "R1 top data", top_data, '0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(idx_top == 7'd31, "R10 idle without valid", DW'(idx_top), 31);

      issue(3'd1, '0, "R9 drop on empty");
      issue(3'd2, '0, "R9 dup on empty");
      issue(3'd0, 32'd10, "R3 push");
      issue(3'd0, 32'd20, "R3 push");
      issue(3'd5, '0, "R9 rot depth two");
      issue(3'd0, 32'd30, "R3 push");
      issue(3'd5, '0, "R7 rot");
      issue(3'd3, '0, "R6 swap");
      issue(3'd4, '0, "R5 over");
      issue(3'd2, '0, "R5 dup");
      issue(3'd6, '0, "R8 add");
      issue(3'd7, '0, "R11 no-op");
      issue(3'd1, '0, "R4 drop");
      issue(3'd6, '0, "R8 add");
      issue(3'd6, '0, "R8 add");
      issue(3'd6, '0, "R9 add depth one");
      issue(3'd3, '0, "R9 swap depth one");
      issue(3'd4, '0, "R9 over depth one");
      issue(3'd2, '0, "R12 clear after good word");
      issue(3'd1, '0, "R4 drop");
      issue(3'd0, 32'hFFFF_FFFF, "R3 push");
      issue(3'd0, 32'd2, "R3 push");
      issue(3'd6, '0, "R8 add wrap");
      issue(3'd1, '0, "R4 drop");
      issue(3'd1, '0, "R4 drop to empty");
      issue(3'd7, '0, "R11 no-op on empty");
      for (int i = 0; i < 96; i++) issue(3'd0, 32'h100 + i, "R3 fill");
      issue(3'd0, 32'hDEAD, "R3 push when full");
      issue(3'd2, '0, "R5 dup when full");
      issue(3'd4, '0, "R5 over when full");
      issue(3'd3, '0, "R6 swap when full");
      issue(3'd5, '0, "R7 rot when full");
      for (int i = 0; i < 4; i++) issue(3'd1, '0, "R4 drop after full");
      for (int i = 0; i < 92; i++) issue(3'd1, '0, "R4 drain");
      issue(3'd1, '0, "R9 drop after drain");
      repeat (4) @(negedge clk);
      chk(sb.size() == 0, "R10 all words completed", DW'(sb.size()), 0);
      finished = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule